// File: doc/BRIEF.md
# Multi-Channel Tick Divider with Fractional Correction

This block divides a shared periodic base tick into several independent event streams. Each channel holds an interval count that falls by one on every base tick. When the count runs out, the channel emits a one-cycle event pulse and reloads from its programmed interval value. A second, smaller correction counter per channel counts expirations. Every time it runs out, the next interval is made one base tick longer. Ratios that are not whole numbers therefore average out over time.

Software sets up a channel with a single write through an address, data and write-enable port. The write carries both the interval value and the correction value. It loads both running counters and starts the channel at once. Writing an interval value of zero parks the channel, and a parked channel neither counts nor fires. All channels run side by side, and any number of them may fire on the same base tick.

Top module: `tick_divider_bank`

## Requirements
- R1: While reset is asserted and after it is released, every channel is idle and `event_o` is all zeros until a channel is configured.
- R2: A channel whose running interval count is zero does not count and never raises its bit of `event_o`.
- R3: An active channel lowers its running count by exactly one on each cycle where `base_tick` is 1. Cycles where `base_tick` is 0 leave it unchanged.
- R4: A channel loaded with interval N (N ≥ 1) and correction 0 raises its event once every N base ticks. At each expiry it reloads N.
- R5: A channel loaded with interval N and correction C ≥ 1 decrements its correction count at each expiry. The expiry that takes that count from 1 to 0 reloads N+1 instead of N and restores the correction count to C. This includes N at its full-scale value, where N+1 needs one extra counter bit.
- R6: A correction value of 0 never lengthens an interval.
- R7: A write with `cfg_we`=1 to channel `cfg_addr` (channel index = address value) stores the interval and correction values. It loads them into the running counters and suppresses that channel's event in that cycle, even when `base_tick` is also 1. A written interval of 0 deactivates the channel.
- R8: Channels are independent. Two channels may raise their events on the same base tick, and configuring one channel leaves the others' timing untouched.
- R9: Each bit of `event_o` is a registered pulse. It is 1 only in the cycle right after a clock edge at which `base_tick` was 1 and that channel expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base tick qualifier, one cycle per tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CH_AW | Channel index to configure |
| cfg_intv | input | INTV_W | Interval reload value (0 = park channel) |
| cfg_corr | input | CORR_W | Correction reload value (0 = no stretching) |
| event_o | output | NUM_CH | Per-channel one-cycle expiry pulses |

## Verification
The bench builds the block with four channels, a 6-bit interval width and a 3-bit correction width. With these widths a full-scale interval of 63 and its stretched length of 64 fit in a few hundred cycles. This exercises the extra counter bit that the correction needs. The small correction width also brings several correction periods into a short run. The bench also covers simultaneous expiry, a write colliding with a tick, and parking a running channel.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STEP   = 2'd2,
        OP_EXPIRE = 2'd3
    } ch_op_e;

    function automatic int addr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdiv_cfg_decode.sv
module tdiv_cfg_decode #(
    parameter int NUM_CH = 4,
    parameter int CH_AW  = 2
) (
    input  logic              we_i,
    input  logic [CH_AW-1:0]  addr_i,
    output logic [NUM_CH-1:0] sel_o
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign sel_o[i] = we_i && (addr_i == CH_AW'(i));
    end

endmodule

// File: rtl/tdiv_channel.sv
module tdiv_channel
    import tdiv_pkg::*;
#(
    parameter int INTV_W = 16,
    parameter int CORR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [INTV_W-1:0] load_intv_i,
    input  logic [CORR_W-1:0] load_corr_i,
    output logic              expire_o
);

    localparam int CNT_W = INTV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CORR_W-1:0] xcnt;
        logic [INTV_W-1:0] intv_rst;
        logic [CORR_W-1:0] corr_rst;
    } chan_st_t;

    chan_st_t st_d, st_q;
    ch_op_e   op;
    logic     expire_d;

    always_comb begin
        if (load_i)
            op = OP_LOAD;
        else if (tick_i && (st_q.cnt != '0))
            op = (st_q.cnt == CNT_W'(1)) ? OP_EXPIRE : OP_STEP;
        else
            op = OP_HOLD;

        st_d     = st_q;
        expire_d = 1'b0;
        case (op)
            OP_LOAD: begin
                st_d.intv_rst = load_intv_i;
                st_d.corr_rst = load_corr_i;
                st_d.cnt      = {1'b0, load_intv_i};
                st_d.xcnt     = load_corr_i;
            end
            OP_STEP: begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            OP_EXPIRE: begin
                expire_d = 1'b1;
                st_d.cnt = {1'b0, st_q.intv_rst};
                if (st_q.xcnt != '0) begin
                    if (st_q.xcnt == CORR_W'(1)) begin
                        st_d.cnt  = {1'b0, st_q.intv_rst} + CNT_W'(1);
                        st_d.xcnt = st_q.corr_rst;
                    end else begin
                        st_d.xcnt = st_q.xcnt - CORR_W'(1);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign expire_o = expire_d;

    // Idle channel stays silent
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !expire_o);

    // No tick, no write: count frozen
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(st_q.cnt));

    // Tick on an active channel above one: count falls by one
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && st_q.cnt > CNT_W'(1)) |=>
        (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    // Expiry reloads the programmed interval (possibly stretched)
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && st_q.cnt == CNT_W'(1)) |=>
        (st_q.cnt == {1'b0, st_q.intv_rst} ||
         st_q.cnt == {1'b0, st_q.intv_rst} + CNT_W'(1)));

    // Correction run-out stretches the next interval and re-arms
    assert_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && st_q.cnt == CNT_W'(1) && st_q.xcnt == CORR_W'(1)) |=>
        (st_q.cnt == {1'b0, st_q.intv_rst} + CNT_W'(1) && st_q.xcnt == st_q.corr_rst));

    // Zero correction count never becomes nonzero without a write
    assert_nocorr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.xcnt == '0 && !load_i) |=> (st_q.xcnt == '0));

    // A write loads the running count from the write data
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == {1'b0, $past(load_intv_i)} && st_q.xcnt == $past(load_corr_i)));

endmodule

// File: rtl/tdiv_event_stage.sv
module tdiv_event_stage #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NUM_CH-1:0] expire_i,
    output logic [NUM_CH-1:0] event_o
);

    logic [NUM_CH-1:0] ev_d, ev_q;

    always_comb begin
        ev_d = expire_i & {NUM_CH{tick_i}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ev_q <= '0;
        else
            ev_q <= ev_d;
    end

    assign event_o = ev_q;

    // No tick on an edge: no event in the following cycle
    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (event_o == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // Any event bit must follow a ticked edge at which its channel expired
        assert_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[i] |-> ($past(tick_i) && $past(expire_i[i])));
    end

endmodule

// File: rtl/tick_divider_bank.sv
module tick_divider_bank
    import tdiv_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int INTV_W = 16,
    parameter int CORR_W = 8,
    parameter int CH_AW  = addr_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              cfg_we,
    input  logic [CH_AW-1:0]  cfg_addr,
    input  logic [INTV_W-1:0] cfg_intv,
    input  logic [CORR_W-1:0] cfg_corr,
    output logic [NUM_CH-1:0] event_o
);

    logic [NUM_CH-1:0] load_sel;
    logic [NUM_CH-1:0] expire;

    tdiv_cfg_decode #(
        .NUM_CH (NUM_CH),
        .CH_AW  (CH_AW)
    ) u_dec (
        .we_i   (cfg_we),
        .addr_i (cfg_addr),
        .sel_o  (load_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tdiv_channel #(
            .INTV_W (INTV_W),
            .CORR_W (CORR_W)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (base_tick),
            .load_i      (load_sel[i]),
            .load_intv_i (cfg_intv),
            .load_corr_i (cfg_corr),
            .expire_o    (expire[i])
        );
    end

    tdiv_event_stage #(
        .NUM_CH (NUM_CH)
    ) u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (base_tick),
        .expire_i (expire),
        .event_o  (event_o)
    );

    // A written channel reports no event in the cycle after the write
    for (genvar i = 0; i < NUM_CH; i++) begin : g_wchk
        assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            load_sel[i] |=> !event_o[i]);
    end

endmodule

// File: tb/sim_tick_divider_bank.sv
module sim_tick_divider_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int IW  = 6;
    localparam int CW  = 3;
    localparam int AW  = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           base_tick;
    logic           cfg_we;
    logic [AW-1:0]  cfg_addr;
    logic [IW-1:0]  cfg_intv;
    logic [CW-1:0]  cfg_corr;
    logic [NCH-1:0] event_o;

    tick_divider_bank #(
        .NUM_CH (NCH),
        .INTV_W (IW),
        .CORR_W (CW)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_intv  (cfg_intv),
        .cfg_corr  (cfg_corr),
        .event_o   (event_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int m_cnt[NCH];
    int m_xc[NCH];
    int m_ir[NCH];
    int m_cr[NCH];
    int ev_count[NCH];
    logic [NCH-1:0] exp_ev;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string tag;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // One clock cycle with the given inputs; reference model steps alongside.
    task automatic cyc(input bit tk, input bit we, input int ad, input int iv, input int cv);
        base_tick = tk;
        cfg_we    = we;
        cfg_addr  = AW'(ad);
        cfg_intv  = IW'(iv);
        cfg_corr  = CW'(cv);
        for (int c = 0; c < NCH; c++) begin
            exp_ev[c] = 1'b0;
            if (we && ad == c) begin
                m_ir[c] = iv; m_cr[c] = cv; m_cnt[c] = iv; m_xc[c] = cv;
            end else if (tk && m_cnt[c] != 0) begin
                m_cnt[c] = m_cnt[c] - 1;
                if (m_cnt[c] == 0) begin
                    exp_ev[c] = 1'b1;
                    m_cnt[c] = m_ir[c];
                    if (m_xc[c] != 0) begin
                        m_xc[c] = m_xc[c] - 1;
                        if (m_xc[c] == 0) begin
                            m_cnt[c] = m_cnt[c] + 1;
                            m_xc[c] = m_cr[c];
                        end
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(event_o === exp_ev, tag, int'(event_o), int'(exp_ev));
        for (int c = 0; c < NCH; c++)
            if (event_o[c]) ev_count[c]++;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 0, 0, 0);
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NCH; c++) ev_count[c] = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0; m_xc[c] = 0; m_ir[c] = 0; m_cr[c] = 0; ev_count[c] = 0;
        end
        rst_n = 1'b0; base_tick = 1'b1; cfg_we = 1'b0;
        cfg_addr = '0; cfg_intv = '0; cfg_corr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(event_o == '0, "R1 reset", int'(event_o), 0);
        rst_n = 1'b1;

        tag = "R1/R2 idle after reset";
        clear_counts();
        ticks(6);
        check(ev_count[0] + ev_count[1] + ev_count[2] + ev_count[3] == 0, "R2 idle count",
              ev_count[0] + ev_count[1] + ev_count[2] + ev_count[3], 0);

        tag = "R4 period";
        cyc(1'b0, 1'b1, 0, 3, 0);
        clear_counts();
        ticks(12);
        check(ev_count[0] == 4, "R4 ch0 events in 12 ticks", ev_count[0], 4);

        tag = "R3 sparse ticks";
        cyc(1'b0, 1'b1, 0, 3, 0);
        clear_counts();
        for (int k = 0; k < 12; k++) begin
            cyc(1'b1, 1'b0, 0, 0, 0);
            cyc(1'b0, 1'b0, 0, 0, 0);
        end
        check(ev_count[0] == 4, "R3 ch0 events in 12 ticks over 24 cycles", ev_count[0], 4);

        tag = "R5 correction";
        cyc(1'b0, 1'b1, 1, 3, 2);
        clear_counts();
        ticks(17);
        check(ev_count[1] == 5, "R5 ch1 events in 17 ticks (3,3,4,3,4)", ev_count[1], 5);

        tag = "R6 no correction";
        cyc(1'b0, 1'b1, 2, 2, 0);
        clear_counts();
        ticks(10);
        check(ev_count[2] == 5, "R6 ch2 events in 10 ticks", ev_count[2], 5);

        tag = "R8 simultaneous";
        cyc(1'b0, 1'b1, 0, 2, 0);
        cyc(1'b0, 1'b1, 2, 2, 0);
        ticks(1);
        ticks(1);
        check(event_o[0] && event_o[2], "R8 ch0 and ch2 together", int'(event_o), 5);

        tag = "R7 deactivate";
        cyc(1'b0, 1'b1, 1, 0, 3);
        clear_counts();
        ticks(10);
        check(ev_count[1] == 0, "R7 parked ch1 events", ev_count[1], 0);
        check(ev_count[0] == 5, "R8 ch0 unaffected by ch1 write", ev_count[0], 5);

        tag = "R7 write wins";
        cyc(1'b0, 1'b1, 3, 1, 0);
        ticks(1);
        check(event_o[3] == 1'b1, "R4 ch3 interval 1 fires", int'(event_o[3]), 1);
        cyc(1'b1, 1'b1, 3, 1, 0);
        check(event_o[3] == 1'b0, "R7 write suppresses same-cycle event", int'(event_o[3]), 0);

        tag = "R9 no tick";
        clear_counts();
        for (int k = 0; k < 6; k++) cyc(1'b0, 1'b0, 0, 0, 0);
        check(ev_count[0] + ev_count[2] + ev_count[3] == 0, "R9 events without tick",
              ev_count[0] + ev_count[2] + ev_count[3], 0);

        tag = "R5 full scale";
        cyc(1'b0, 1'b1, 3, 63, 1);
        clear_counts();
        ticks(200);
        check(ev_count[3] == 3, "R5 ch3 intervals 63,64,64 in 200 ticks", ev_count[3], 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule